// File: doc/BRIEF.md
# Translation Cache Maintenance and Fault Status Controller

This block is the register-facing control unit that sits beside the translation caches and fault logic of an address-translation unit. Software uses it to request flushes of individual micro TLBs, the shared macro TLB and the page-walk cache, to start address-range invalidations in the TLB and in the walk cache, to enable, observe and acknowledge translation faults, and to hold individual bus masters in reset while their state is cleaned up. The cache arrays themselves live elsewhere: this block issues a one-cycle invalidate strobe per target and waits for that target's done input.

Every maintenance command is a bit that software writes as 1. The bit reads back as 1 while the operation is outstanding and drops to 0 by itself once the target has reported done and a programmable minimum number of busy cycles has gone by, so a driver simply polls the bit. Fault events set sticky status bits that are acknowledged by writing ones to a separate clear register; the interrupt line is the OR of the enabled status bits. The master reset register is active low per bit: writing a word with zeros at some masters holds them in reset, and writing all ones releases every master.

The register port is plain: a write takes effect at the clock edge where `reg_wr` is high, and a read request on `reg_rd` returns its data on `reg_rdata` from the following cycle until the next read. There is no back-pressure: the block accepts one access per cycle.

Top module: `mmu_maint_ctrl`

## Requirements
- R1: After reset all masters are released (`master_rst_n` all ones and offset 0x010 reads all master bits as 1), `xlat_en`, `clk_gate_en`, `irq` and every strobe are 0, and the command, status and enable registers read 0.
- R2: A write to offset 0x080 starts one flush per bit written as 1: bits 0 to NUM_MASTERS-1 select the micro TLBs (`flush_stb[i]`), bit 16 the macro TLB (`flush_stb[NUM_MASTERS]`), bit 17 the walk cache (`flush_stb[NUM_MASTERS+1]`); each started target gets exactly one one-cycle strobe in the cycle after the write, and its bit reads 1 in 0x080 while it is busy.
- R3: A busy bit returns to 0 only after the target's done input has been seen during the busy period and at least OP_MIN_CYCLES busy cycles have passed; a done pulse while the target is idle has no effect.
- R4: Writing 1 to a command bit that is already busy gives no further strobe, and writing 0 to any command bit neither starts nor aborts an operation.
- R5: Offsets 0x090 and 0x094 hold the TLB range address and mask, driven on `tlb_inv_addr` and `tlb_inv_mask` and readable; writing bit 0 of 0x098 as 1 strobes `tlb_inv_stb` once, bit 0 of 0x098 reads 1 until completion under the rule of R3 with `tlb_inv_done`.
- R6: Offset 0x0A0 holds the walk-cache range address, driven on `walk_inv_addr`; writing bit 0 of 0x0A8 as 1 strobes `walk_inv_stb` once and bit 0 of 0x0A8 self-clears under the rule of R3 with `walk_inv_done`.
- R7: Fault inputs set sticky bits in the status register at 0x108: bit 16 from `fault_l1`, bit 17 from `fault_l2`, bit i from `fault_perm[i]`; a bit stays set until cleared.
- R8: Writing to 0x104 clears each status bit written as 1; a fault event in the same cycle as the clear of its bit leaves that bit set. 0x104 reads 0.
- R9: `irq` is high exactly when some status bit is set whose bit at the same position in the enable register at 0x100 is 1, from the cycle after the status or enable change.
- R10: The low NUM_MASTERS bits written to 0x010 drive `master_rst_n` directly (a 0 holds that master in reset); writing 0xFFFFFFFF releases all masters.
- R11: Bit 0 of 0x020 drives `xlat_en` and bit 0 of 0x040 drives `clk_gate_en`; both read back.
- R12: Reads of unmapped offsets return 0 and writes to them change no output or register; read data appears on `reg_rdata` the cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| flush_stb | output | NUM_MASTERS+2 | Flush strobes: micro TLBs, then macro TLB, then walk cache |
| flush_done | input | NUM_MASTERS+2 | Flush completion pulses, same ordering |
| tlb_inv_stb | output | 1 | TLB range invalidate strobe |
| tlb_inv_addr | output | 32 | TLB range invalidate address |
| tlb_inv_mask | output | 32 | TLB range invalidate mask |
| tlb_inv_done | input | 1 | TLB range invalidate completion |
| walk_inv_stb | output | 1 | Walk-cache range invalidate strobe |
| walk_inv_addr | output | 32 | Walk-cache range invalidate address |
| walk_inv_done | input | 1 | Walk-cache range invalidate completion |
| fault_l1 | input | 1 | First-level entry invalid event |
| fault_l2 | input | 1 | Second-level entry invalid event |
| fault_perm | input | NUM_MASTERS | Per-master permission fault events |
| irq | output | 1 | Interrupt request |
| master_rst_n | output | NUM_MASTERS | Per-master reset, active low |
| xlat_en | output | 1 | Global translation enable |
| clk_gate_en | output | 1 | Automatic clock-gating enable |

## Verification
The hardest cases to reach from the ports are the ones where timing of the done input and the busy window interact: a done that arrives before the minimum busy time has elapsed, a done that arrives while the target is idle, and a repeated start while busy. The bench drives done pulses from its own tasks at chosen cycles relative to the command write and then polls the command bit through ordinary reads, so the moment of self-clearing is observed exactly as software would see it. The same-cycle collision of a fault event with the clear of its own status bit is produced by one task that raises the fault input and the clear write on the same clock edge.

// File: rtl/mmu_maint_pkg.sv
package mmu_maint_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_MRST    = 12'h010;
  localparam logic [REG_AW-1:0] OFS_XEN     = 12'h020;
  localparam logic [REG_AW-1:0] OFS_CGATE   = 12'h040;
  localparam logic [REG_AW-1:0] OFS_FLUSH   = 12'h080;
  localparam logic [REG_AW-1:0] OFS_TADDR   = 12'h090;
  localparam logic [REG_AW-1:0] OFS_TMASK   = 12'h094;
  localparam logic [REG_AW-1:0] OFS_TGO     = 12'h098;
  localparam logic [REG_AW-1:0] OFS_WADDR   = 12'h0A0;
  localparam logic [REG_AW-1:0] OFS_WGO     = 12'h0A8;
  localparam logic [REG_AW-1:0] OFS_IEN     = 12'h100;
  localparam logic [REG_AW-1:0] OFS_ICLR    = 12'h104;
  localparam logic [REG_AW-1:0] OFS_ISTAT   = 12'h108;

  localparam int BIT_MACRO = 16;
  localparam int BIT_WALK  = 17;
  localparam int BIT_L1    = 16;
  localparam int BIT_L2    = 17;
  localparam int STAT_W    = 18;

  // Bit of the flush register that controls flush target idx.
  function automatic int flush_bit(input int idx, input int nm);
    if (idx < nm) return idx;
    else if (idx == nm) return BIT_MACRO;
    else return BIT_WALK;
  endfunction
endpackage

// File: rtl/mmu_maint_op.sv
module mmu_maint_op #(
  parameter int MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o,
  output logic stb_o
);
  localparam int MC = (MIN_CYCLES < 1) ? 1 : MIN_CYCLES;
  localparam int CW = $clog2(MC + 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          reached;

  assign reached = (cnt_q >= CW'(MC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      stb_o  <= 1'b0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          stb_o  <= 1'b1;
          cnt_q  <= '0;
          seen_q <= 1'b0;
        end
      end else begin
        if (done_i) seen_q <= 1'b1;
        if (!reached) cnt_q <= cnt_q + CW'(1);
        if ((seen_q || done_i) && reached) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mmu_maint_fault.sv
module mmu_maint_fault
  import mmu_maint_pkg::*;
#(
  parameter int NUM_MASTERS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   l1_i,
  input  logic                   l2_i,
  input  logic [NUM_MASTERS-1:0] perm_i,
  input  logic                   clr_we_i,
  input  logic                   en_we_i,
  input  logic [REG_DW-1:0]      wdata_i,
  output logic [STAT_W-1:0]      status_o,
  output logic [STAT_W-1:0]      enable_o,
  output logic                   irq_o
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] valid_mask;

  always_comb begin
    set_vec = '0;
    valid_mask = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      set_vec[i]    = perm_i[i];
      valid_mask[i] = 1'b1;
    end
    set_vec[BIT_L1]    = l1_i;
    set_vec[BIT_L2]    = l2_i;
    valid_mask[BIT_L1] = 1'b1;
    valid_mask[BIT_L2] = 1'b1;
    clr_vec = clr_we_i ? wdata_i[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      enable_o <= '0;
    end else begin
      status_o <= ((status_o & ~clr_vec) | set_vec) & valid_mask;
      if (en_we_i) enable_o <= wdata_i[STAT_W-1:0] & valid_mask;
    end
  end

  assign irq_o = |(status_o & enable_o);
endmodule

// File: rtl/mmu_maint_ctrl.sv
module mmu_maint_ctrl
  import mmu_maint_pkg::*;
#(
  parameter int NUM_MASTERS   = 6,
  parameter int OP_MIN_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [REG_DW-1:0]        reg_wdata,
  output logic [REG_DW-1:0]        reg_rdata,
  output logic [NUM_MASTERS+1:0]   flush_stb,
  input  logic [NUM_MASTERS+1:0]   flush_done,
  output logic                     tlb_inv_stb,
  output logic [REG_DW-1:0]        tlb_inv_addr,
  output logic [REG_DW-1:0]        tlb_inv_mask,
  input  logic                     tlb_inv_done,
  output logic                     walk_inv_stb,
  output logic [REG_DW-1:0]        walk_inv_addr,
  input  logic                     walk_inv_done,
  input  logic                     fault_l1,
  input  logic                     fault_l2,
  input  logic [NUM_MASTERS-1:0]   fault_perm,
  output logic                     irq,
  output logic [NUM_MASTERS-1:0]   master_rst_n,
  output logic                     xlat_en,
  output logic                     clk_gate_en
);
  localparam int NF = NUM_MASTERS + 2;

  logic              wr_flush, wr_tgo, wr_wgo;
  logic [NF-1:0]     flush_start;
  logic [NF-1:0]     flush_busy;
  logic              tlb_busy, walk_busy;
  logic [STAT_W-1:0] stat_q, ien_q;
  logic [REG_DW-1:0] flush_view;
  logic [REG_DW-1:0] rd_mux;

  assign wr_flush = reg_wr && (reg_addr == OFS_FLUSH);
  assign wr_tgo   = reg_wr && (reg_addr == OFS_TGO);
  assign wr_wgo   = reg_wr && (reg_addr == OFS_WGO);

  // One tracker per flush target.
  for (genvar g = 0; g < NF; g++) begin : g_flush
    localparam int BP = flush_bit(g, NUM_MASTERS);
    assign flush_start[g] = wr_flush && reg_wdata[BP];
    mmu_maint_op #(.MIN_CYCLES(OP_MIN_CYCLES)) u_op (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(flush_start[g]),
      .done_i (flush_done[g]),
      .busy_o (flush_busy[g]),
      .stb_o  (flush_stb[g])
    );
  end

  mmu_maint_op #(.MIN_CYCLES(OP_MIN_CYCLES)) u_tlb_op (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(wr_tgo && reg_wdata[0]),
    .done_i (tlb_inv_done),
    .busy_o (tlb_busy),
    .stb_o  (tlb_inv_stb)
  );

  mmu_maint_op #(.MIN_CYCLES(OP_MIN_CYCLES)) u_walk_op (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(wr_wgo && reg_wdata[0]),
    .done_i (walk_inv_done),
    .busy_o (walk_busy),
    .stb_o  (walk_inv_stb)
  );

  mmu_maint_fault #(.NUM_MASTERS(NUM_MASTERS)) u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .l1_i    (fault_l1),
    .l2_i    (fault_l2),
    .perm_i  (fault_perm),
    .clr_we_i(reg_wr && (reg_addr == OFS_ICLR)),
    .en_we_i (reg_wr && (reg_addr == OFS_IEN)),
    .wdata_i (reg_wdata),
    .status_o(stat_q),
    .enable_o(ien_q),
    .irq_o   (irq)
  );

  // Plain control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_rst_n  <= '1;
      xlat_en       <= 1'b0;
      clk_gate_en   <= 1'b0;
      tlb_inv_addr  <= '0;
      tlb_inv_mask  <= '0;
      walk_inv_addr <= '0;
    end else if (reg_wr) begin
      unique case (reg_addr)
        OFS_MRST:  master_rst_n  <= reg_wdata[NUM_MASTERS-1:0];
        OFS_XEN:   xlat_en       <= reg_wdata[0];
        OFS_CGATE: clk_gate_en   <= reg_wdata[0];
        OFS_TADDR: tlb_inv_addr  <= reg_wdata;
        OFS_TMASK: tlb_inv_mask  <= reg_wdata;
        OFS_WADDR: walk_inv_addr <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    flush_view = '0;
    for (int i = 0; i < NF; i++) flush_view[flush_bit(i, NUM_MASTERS)] = flush_busy[i];
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      OFS_MRST:  rd_mux[NUM_MASTERS-1:0] = master_rst_n;
      OFS_XEN:   rd_mux[0] = xlat_en;
      OFS_CGATE: rd_mux[0] = clk_gate_en;
      OFS_FLUSH: rd_mux = flush_view;
      OFS_TADDR: rd_mux = tlb_inv_addr;
      OFS_TMASK: rd_mux = tlb_inv_mask;
      OFS_TGO:   rd_mux[0] = tlb_busy;
      OFS_WADDR: rd_mux = walk_inv_addr;
      OFS_WGO:   rd_mux[0] = walk_busy;
      OFS_IEN:   rd_mux[STAT_W-1:0] = ien_q;
      OFS_ISTAT: rd_mux[STAT_W-1:0] = stat_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mmu_maint_chk.sv
module mmu_maint_chk
  import mmu_maint_pkg::*;
#(
  parameter int NUM_MASTERS = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic [REG_AW-1:0]      reg_addr,
  input logic [REG_DW-1:0]      reg_wdata,
  input logic [NUM_MASTERS+1:0] flush_stb,
  input logic                   tlb_inv_stb,
  input logic                   walk_inv_stb,
  input logic                   irq,
  input logic [NUM_MASTERS-1:0] master_rst_n
);
  AST_FLUSH_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush_stb & $past(flush_stb)) == '0)); // R2

  AST_FLUSH_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_stb != '0) |-> $past(reg_wr && reg_addr == OFS_FLUSH)); // R2

  AST_TLB_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inv_stb |=> !tlb_inv_stb); // R5

  AST_WALK_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_inv_stb |-> $past(reg_wr && reg_addr == OFS_WGO && reg_wdata[0])); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && (reg_addr == OFS_ICLR || reg_addr == OFS_IEN))) |=> irq); // R7

  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_MRST && reg_wdata == 32'hFFFF_FFFF) |=> (&master_rst_n)); // R10
endmodule

bind mmu_maint_ctrl mmu_maint_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .flush_stb   (flush_stb),
  .tlb_inv_stb (tlb_inv_stb),
  .walk_inv_stb(walk_inv_stb),
  .irq         (irq),
  .master_rst_n(master_rst_n)
);

// File: tb/tb_mmu_maint_ctrl.sv
module tb_mmu_maint_ctrl;
  localparam int NM  = 6;
  localparam int NF  = NM + 2;
  localparam int MIN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NF-1:0] flush_stb;
  logic [NF-1:0] flush_done = '0;
  logic          tlb_inv_stb, walk_inv_stb;
  logic [31:0]   tlb_inv_addr, tlb_inv_mask, walk_inv_addr;
  logic          tlb_inv_done = 1'b0, walk_inv_done = 1'b0;
  logic          fault_l1 = 1'b0, fault_l2 = 1'b0;
  logic [NM-1:0] fault_perm = '0;
  logic          irq;
  logic [NM-1:0] master_rst_n;
  logic          xlat_en, clk_gate_en;

  int checks = 0;
  int failures = 0;
  int fl_cnt [NF];
  int tlb_cnt = 0;
  int walk_cnt = 0;

  always #4 clk = ~clk;

  mmu_maint_ctrl #(.NUM_MASTERS(NM), .OP_MIN_CYCLES(MIN)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flush_stb(flush_stb), .flush_done(flush_done),
    .tlb_inv_stb(tlb_inv_stb), .tlb_inv_addr(tlb_inv_addr),
    .tlb_inv_mask(tlb_inv_mask), .tlb_inv_done(tlb_inv_done),
    .walk_inv_stb(walk_inv_stb), .walk_inv_addr(walk_inv_addr),
    .walk_inv_done(walk_inv_done), .fault_l1(fault_l1), .fault_l2(fault_l2),
    .fault_perm(fault_perm), .irq(irq), .master_rst_n(master_rst_n),
    .xlat_en(xlat_en), .clk_gate_en(clk_gate_en)
  );

  always @(negedge clk) begin
    for (int i = 0; i < NF; i++) if (flush_stb[i]) fl_cnt[i]++;
    if (tlb_inv_stb) tlb_cnt++;
    if (walk_inv_stb) walk_cnt++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_flush_done(input logic [NF-1:0] m);
    @(negedge clk); flush_done = m;
    @(negedge clk); flush_done = '0;
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NF; i++) fl_cnt[i] = 0;
    tlb_cnt = 0; walk_cnt = 0;
  endtask

  // R1
  task automatic t_reset();
    logic [31:0] d;
    chk_eq("R1 master_rst_n", 32'(master_rst_n), 32'h3F);
    chk_eq("R1 enables/irq", {29'd0, xlat_en, clk_gate_en, irq}, 32'd0);
    chk_eq("R1 strobes", {23'd0, flush_stb, tlb_inv_stb}, 32'd0);
    rd(12'h010, d); chk_eq("R1 reset reg", d, 32'h3F);
    rd(12'h080, d); chk_eq("R1 flush reg", d, 32'h0);
    rd(12'h108, d); chk_eq("R1 status", d, 32'h0);
    rd(12'h100, d); chk_eq("R1 irq enable", d, 32'h0);
  endtask

  // R2: two distinct bit patterns
  task automatic t_flush_pattern(input logic [31:0] cmd, input logic [NF-1:0] tgt);
    logic [31:0] d;
    clear_counts();
    wr(12'h080, cmd);
    rd(12'h080, d); chk_eq("R2 busy view", d, cmd);
    for (int i = 0; i < NF; i++)
      chk_eq($sformatf("R2 strobe count target %0d", i), fl_cnt[i], tgt[i] ? 1 : 0);
    pulse_flush_done('1);
    idle(MIN + 2);
    rd(12'h080, d); chk_eq("R2 R3 self clear", d, 32'h0);
  endtask

  // R3
  task automatic t_min_latency();
    logic [31:0] d;
    wr(12'h080, 32'h0001_0000);
    pulse_flush_done(NF'(1) << NM);
    rd(12'h080, d); chk_eq("R3 busy kept before min cycles", d, 32'h0001_0000);
    idle(4);
    rd(12'h080, d); chk_eq("R3 clear after min cycles", d, 32'h0);
    // done while idle must not be remembered
    pulse_flush_done(NF'(1) << 3);
    wr(12'h080, 32'h8);
    idle(20);
    rd(12'h080, d); chk_eq("R3 idle done ignored", d, 32'h8);
    pulse_flush_done(NF'(1) << 3);
    idle(MIN + 2);
    rd(12'h080, d); chk_eq("R3 clear after done", d, 32'h0);
  endtask

  // R4
  task automatic t_busy_rewrite();
    logic [31:0] d;
    clear_counts();
    wr(12'h080, 32'h10);
    wr(12'h080, 32'h10);
    wr(12'h080, 32'h0);
    idle(2);
    chk_eq("R4 single strobe", fl_cnt[4], 1);
    rd(12'h080, d); chk_eq("R4 zero write no abort", d, 32'h10);
    pulse_flush_done(NF'(1) << 4);
    idle(MIN + 2);
    rd(12'h080, d); chk_eq("R4 completes", d, 32'h0);
  endtask

  // R5
  task automatic t_tlb_range();
    logic [31:0] d;
    clear_counts();
    wr(12'h090, 32'h1234_5000);
    wr(12'h094, 32'hFFFF_F000);
    chk_eq("R5 addr out", tlb_inv_addr, 32'h1234_5000);
    chk_eq("R5 mask out", tlb_inv_mask, 32'hFFFF_F000);
    rd(12'h094, d); chk_eq("R5 mask readback", d, 32'hFFFF_F000);
    wr(12'h098, 32'h1);
    rd(12'h098, d); chk_eq("R5 busy", d, 32'h1);
    chk_eq("R5 strobe count", tlb_cnt, 1);
    @(negedge clk); tlb_inv_done = 1'b1;
    @(negedge clk); tlb_inv_done = 1'b0;
    idle(MIN + 2);
    rd(12'h098, d); chk_eq("R5 self clear", d, 32'h0);
  endtask

  // R6
  task automatic t_walk_range();
    logic [31:0] d;
    clear_counts();
    wr(12'h0A0, 32'h8010_0000);
    chk_eq("R6 addr out", walk_inv_addr, 32'h8010_0000);
    wr(12'h0A8, 32'h1);
    rd(12'h0A8, d); chk_eq("R6 busy", d, 32'h1);
    chk_eq("R6 strobe count", walk_cnt, 1);
    @(negedge clk); walk_inv_done = 1'b1;
    @(negedge clk); walk_inv_done = 1'b0;
    idle(MIN + 2);
    rd(12'h0A8, d); chk_eq("R6 self clear", d, 32'h0);
  endtask

  // R7, R8
  task automatic t_fault_status();
    logic [31:0] d;
    @(negedge clk); fault_l2 = 1'b1; fault_perm = 6'h20;
    @(negedge clk); fault_l2 = 1'b0; fault_perm = '0;
    idle(3);
    rd(12'h108, d); chk_eq("R7 sticky status", d, 32'h0002_0020);
    wr(12'h104, 32'h0002_0000);
    rd(12'h108, d); chk_eq("R8 partial clear", d, 32'h20);
    rd(12'h104, d); chk_eq("R8 clear reg reads 0", d, 32'h0);
    // same-cycle set and clear of bit 2
    @(negedge clk);
    fault_perm = 6'h04; reg_wr = 1'b1; reg_addr = 12'h104; reg_wdata = 32'h24;
    @(negedge clk);
    fault_perm = '0; reg_wr = 1'b0;
    rd(12'h108, d); chk_eq("R8 set wins over clear", d, 32'h4);
    wr(12'h104, 32'hFFFF_FFFF);
    rd(12'h108, d); chk_eq("R8 clear all", d, 32'h0);
  endtask

  // R9
  task automatic t_irq();
    wr(12'h100, 32'h0001_0000);
    chk_eq("R9 no irq without status", irq, 1'b0);
    @(negedge clk); fault_l1 = 1'b1;
    @(negedge clk); fault_l1 = 1'b0;
    chk_eq("R9 irq after l1 fault", irq, 1'b1);
    wr(12'h104, 32'h0001_0000);
    chk_eq("R9 irq drops on clear", irq, 1'b0);
    @(negedge clk); fault_perm = 6'h02;
    @(negedge clk); fault_perm = '0;
    chk_eq("R9 masked status no irq", irq, 1'b0);
    wr(12'h100, 32'h2);
    chk_eq("R9 irq on enable", irq, 1'b1);
    wr(12'h104, 32'hFFFF_FFFF);
    chk_eq("R9 irq cleared", irq, 1'b0);
  endtask

  // R10
  task automatic t_master_reset();
    logic [31:0] d;
    wr(12'h010, 32'hFFFF_FFED);
    chk_eq("R10 masters held", 32'(master_rst_n), 32'h2D);
    rd(12'h010, d); chk_eq("R10 readback", d, 32'h2D);
    wr(12'h010, 32'hFFFF_FFFF);
    chk_eq("R10 release all", 32'(master_rst_n), 32'h3F);
  endtask

  // R11
  task automatic t_enables();
    logic [31:0] d;
    wr(12'h020, 32'h1);
    wr(12'h040, 32'h1);
    chk_eq("R11 outputs", {30'd0, xlat_en, clk_gate_en}, 32'h3);
    rd(12'h040, d); chk_eq("R11 gate readback", d, 32'h1);
    wr(12'h020, 32'h0);
    chk_eq("R11 xlat off", xlat_en, 1'b0);
  endtask

  // R12
  task automatic t_unmapped();
    logic [31:0] d;
    clear_counts();
    wr(12'h0C0, 32'hFFFF_FFFF);
    wr(12'h084, 32'hFFFF_FFFF);
    wr(12'h014, 32'h0);
    idle(2);
    rd(12'h0C0, d); chk_eq("R12 unmapped read", d, 32'h0);
    chk_eq("R12 reset reg untouched", 32'(master_rst_n), 32'h3F);
    chk_eq("R12 no strobes", fl_cnt[0] + fl_cnt[NM] + tlb_cnt, 0);
    rd(12'h080, d); chk_eq("R12 flush reg untouched", d, 32'h0);
    rd(12'h090, d); chk_eq("R12 readback latency", d, 32'h1234_5000);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_counts();
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_flush_pattern(32'h0001_0005, NF'(8'b0100_0101));
    t_flush_pattern(32'h0002_0022, NF'(8'b1010_0010));
    t_min_latency();
    t_busy_rewrite();
    t_tlb_range();
    t_walk_range();
    t_fault_status();
    t_irq();
    t_master_reset();
    t_enables();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule